// File: doc/BRIEF.md
# Always-On Watchdog Timer with Maskable-Only-At-Output NMI

This block is a watchdog counter for a system that keeps a low-speed oscillator running at all times. The low-speed clock reaches the block as a one-cycle tick enable in the system clock domain. A prescaler divides these ticks by sixteen, and each prescaler carry advances a binary counter. When the counter wraps from all ones to zero, the block raises a one-cycle non-maskable interrupt request, but only if the NMI enable bit is set.

The watchdog is armed straight out of reset. Software keeps it quiet by pulsing the clear strobe often enough, which resets both the counter and the prescaler. Clearing the enable bit only suppresses the interrupt. The counter keeps counting, so software should clear the count before it sets the enable again. A sleep input stands for the stopped oscillator: while it is high, neither the prescaler nor the counter moves.

Top module: `wdt_always_on`

## Requirements
- R1: After reset `count_o` is 0, `nmi_o` is 0, and the NMI enable bit is 1, so a first wrap with no enable write produces an NMI.
- R2: With `sleep_i` low, `count_o` rises by one for every 16 cycles in which `lsclk_tick_i` is high. The step appears after the edge that takes the 16th tick. The count never changes by any amount other than +1, except through a clear or a wrap.
- R3: While `sleep_i` is high, ticks are ignored: neither `count_o` nor the prescaler phase changes. Counting resumes from the same phase when `sleep_i` drops.
- R4: When the count wraps from all ones to 0 and the enable bit is 1, `nmi_o` is high for exactly one cycle. That cycle is the one in which `count_o` first reads 0.
- R5: With the enable bit 0, a wrap produces no NMI, and the counter keeps advancing past zero.
- R6: A one-cycle pulse on `wdt_clr_i` sets `count_o` to 0 after the next edge and also resets the prescaler phase, so 16 further ticks are needed for the next step.
- R7: If `wdt_clr_i` is high in the same cycle as the tick that would wrap the count, the clear wins: `count_o` becomes 0 and no NMI is issued.
- R8: The pulse `nmi_en_wr_i` loads `nmi_en_wdata_i` (1 = NMI allowed, 0 = masked) into the enable bit. A wrap in the same cycle as the write is gated by the old value.
- R9: `nmi_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lsclk_tick_i | input | 1 | One-cycle enable per low-speed clock period |
| sleep_i | input | 1 | High while the low-speed clock is stopped |
| wdt_clr_i | input | 1 | Software clear strobe for counter and prescaler |
| nmi_en_wr_i | input | 1 | Write strobe for the NMI enable bit |
| nmi_en_wdata_i | input | 1 | Value written to the NMI enable bit |
| nmi_o | output | 1 | One-cycle NMI request |
| count_o | output | CNT_W | Current watchdog count |

## Verification
The assertions assume that every strobe and the tick input are synchronous to `clk` and free of glitches. They also assume that a clear is a single request that is seen in the cycle it is asserted. Under these assumptions, any count change is either a +1 step or a return to zero after a clear or a wrap. The bench drives every input on the falling edge and samples on the falling edge. It uses a reduced counter width, so wraps are reached in a few thousand ticks, and it lines clears, sleep and enable writes up exactly with the wrapping tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    parameter int WDT_CNT_W_DEF    = 16;
    parameter int WDT_DIV_LOG2_DEF = 4;

    typedef struct packed {
        logic en;
        logic nmi;
    } wdt_gate_t;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int DIV_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sleep_i,
    input  logic clr_i,
    output logic carry_o
);
    localparam logic [DIV_LOG2-1:0] PRE_LAST = '1;

    typedef struct packed {
        logic [DIV_LOG2-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       live;

    always_comb begin
        st_d    = st_q;
        live    = tick_i & ~sleep_i;
        carry_o = live & (st_q.pre == PRE_LAST) & ~clr_i;
        if (clr_i) begin
            st_d.pre = '0;
        end else if (live) begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = step_i & (&st_q.cnt) & ~clr_i;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/wdt_nmi_gate.sv
module wdt_nmi_gate
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr_i,
    input  logic en_wdata_i,
    input  logic wrap_i,
    output logic nmi_o,
    output logic en_o
);
    wdt_gate_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // wrap is judged against the enable held before this edge
        st_d.nmi = wrap_i & st_q.en;
        if (en_wr_i) begin
            st_d.en = en_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en  <= 1'b1;
            st_q.nmi <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi_o = st_q.nmi;
    assign en_o  = st_q.en;
endmodule

// File: rtl/wdt_always_on.sv
module wdt_always_on
    import wdt_pkg::*;
#(
    parameter int CNT_W    = WDT_CNT_W_DEF,
    parameter int DIV_LOG2 = WDT_DIV_LOG2_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lsclk_tick_i,
    input  logic             sleep_i,
    input  logic             wdt_clr_i,
    input  logic             nmi_en_wr_i,
    input  logic             nmi_en_wdata_i,
    output logic             nmi_o,
    output logic [CNT_W-1:0] count_o
);
    logic pre_carry;
    logic cnt_wrap;
    logic nmi_en;

    wdt_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (lsclk_tick_i),
        .sleep_i (sleep_i),
        .clr_i   (wdt_clr_i),
        .carry_o (pre_carry)
    );

    wdt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (pre_carry),
        .clr_i   (wdt_clr_i),
        .count_o (count_o),
        .wrap_o  (cnt_wrap)
    );

    wdt_nmi_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr_i    (nmi_en_wr_i),
        .en_wdata_i (nmi_en_wdata_i),
        .wrap_i     (cnt_wrap),
        .nmi_o      (nmi_o),
        .en_o       (nmi_en)
    );
endmodule

// File: rtl/wdt_always_on_chk.sv
module wdt_always_on_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_i,
    input logic             wdt_clr_i,
    input logic             nmi_o,
    input logic             nmi_en,
    input logic [CNT_W-1:0] count_o
);
    // R6
    clr_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_i |=> (count_o == '0) && !nmi_o);

    // R3
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !wdt_clr_i) |=> $stable(count_o));

    // R4
    nmi_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> (count_o == '0));

    // R9
    nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o);

    // R5
    nmi_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> $past(nmi_en));

    // R2
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wdt_clr_i) && (count_o != $past(count_o)))
            |-> (count_o == CNT_W'($past(count_o) + 1'b1)));
endmodule

bind wdt_always_on wdt_always_on_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_i   (sleep_i),
    .wdt_clr_i (wdt_clr_i),
    .nmi_o     (nmi_o),
    .nmi_en    (nmi_en),
    .count_o   (count_o)
);

// File: tb/tb_wdt_always_on.sv
module tb_wdt_always_on;
    localparam int CW   = 8;
    localparam int FULL = 16 * (1 << CW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0, sleep = 1'b0, clr = 1'b0, ewr = 1'b0, edat = 1'b0;
    logic          nmi;
    logic [CW-1:0] count;
    int            checks = 0, failures = 0, nmi_seen = 0;

    always #5 clk = ~clk;

    wdt_always_on #(.CNT_W(CW), .DIV_LOG2(4)) dut (
        .clk(clk), .rst_n(rst_n), .lsclk_tick_i(tick), .sleep_i(sleep),
        .wdt_clr_i(clr), .nmi_en_wr_i(ewr), .nmi_en_wdata_i(edat),
        .nmi_o(nmi), .count_o(count)
    );

    // vector table: ticks applied, sleep level, expected count afterwards (R2, R3)
    localparam int NV = 7;
    localparam int V_TICKS [NV] = '{15, 1, 32, 31, 1, 160, 20};
    localparam bit V_SLEEP [NV] = '{0, 0, 1, 0, 0, 0, 1};
    localparam int V_CNT   [NV] = '{0, 1, 1, 2, 3, 13, 13};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_ticks(input int n, input bit slp);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; sleep = slp;
            @(negedge clk);
            if (nmi) nmi_seen++;
        end
        tick = 1'b0; sleep = 1'b0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic write_en(input bit v);
        ewr = 1'b1; edat = v;
        @(negedge clk);
        ewr = 1'b0;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count after reset", int'(count), 0);
        check("R1 nmi after reset", int'(nmi), 0);

        for (int v = 0; v < NV; v++) begin
            run_ticks(V_TICKS[v], V_SLEEP[v]);
            check(V_SLEEP[v] ? "R3 vector count" : "R2 vector count", int'(count), V_CNT[v]);
        end

        // R6: clear also resets the prescaler phase
        run_ticks(7, 0);
        pulse_clr();
        check("R6 count after clear", int'(count), 0);
        run_ticks(15, 0);
        check("R6 prescaler restarted (15 ticks)", int'(count), 0);
        run_ticks(1, 0);
        check("R6 prescaler restarted (16 ticks)", int'(count), 1);

        // R1/R4: first wrap with default enable
        pulse_clr();
        nmi_seen = 0;
        run_ticks(FULL - 1, 0);
        check("R4 count before wrap", int'(count), (1 << CW) - 1);
        check("R4 no early nmi", nmi_seen, 0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R1 R4 nmi on wrap", int'(nmi), 1);
        check("R4 count zero on wrap", int'(count), 0);
        @(negedge clk);
        check("R4 R9 nmi one cycle", int'(nmi), 0);

        // R5: masked wrap, counter continues
        write_en(1'b0);
        pulse_clr();
        nmi_seen = 0;
        run_ticks(FULL, 0);
        check("R5 no nmi when masked", nmi_seen, 0);
        check("R5 count wrapped", int'(count), 0);
        run_ticks(16, 0);
        check("R5 count keeps running", int'(count), 1);

        // R8: re-enable, wrap raises nmi
        write_en(1'b1);
        pulse_clr();
        nmi_seen = 0;
        run_ticks(FULL, 0);
        check("R8 nmi after re-enable", nmi_seen, 1);

        // R7: clear coincides with wrapping tick
        pulse_clr();
        nmi_seen = 0;
        run_ticks(FULL - 1, 0);
        tick = 1'b1; clr = 1'b1;
        @(negedge clk);
        tick = 1'b0; clr = 1'b0;
        check("R7 count after clear at wrap", int'(count), 0);
        check("R7 no nmi", int'(nmi) + nmi_seen, 0);
        @(negedge clk);
        check("R7 no late nmi", int'(nmi), 0);

        // R3: sleep at the wrap point
        pulse_clr();
        nmi_seen = 0;
        run_ticks(FULL - 1, 0);
        run_ticks(3, 1);
        check("R3 count held in sleep", int'(count), (1 << CW) - 1);
        check("R3 no nmi in sleep", nmi_seen, 0);
        run_ticks(1, 0);
        check("R3 resume wraps", nmi_seen, 1);

        // R8: disable written in the wrapping cycle uses old enable
        pulse_clr();
        nmi_seen = 0;
        run_ticks(FULL - 1, 0);
        tick = 1'b1; ewr = 1'b1; edat = 1'b0;
        @(negedge clk);
        tick = 1'b0; ewr = 1'b0;
        check("R8 old enable gates wrap", int'(nmi), 1);
        nmi_seen = 0;
        run_ticks(FULL, 0);
        check("R8 new enable masks later wrap", nmi_seen, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule